// File: doc/BRIEF.md
# Paged Address Translator with Associative Lookaside Cache

This block turns a logical address into a physical address for a memory system built on fixed-size pages. The low bits of the logical address are the byte offset inside a page. The high bits are the page number. A small fully associative cache keeps recent page-to-frame pairs together with their read-only flag. When a request finds its page in the cache, the cached frame is used at once.

When a request misses, the block reads one page-table entry through a memory read port. The entry's address is a base input plus the page number. The block then checks whether the page is present and whether the access is allowed, and it answers either with the frame joined to the offset or with a fault code. Present entries are written into the cache slot that a round-robin pointer selects.

A flush input empties the cache whenever the address space changes. If a flush arrives during a table read, that read still completes and answers, but its result is not cached. Requests and responses use a valid/ready handshake, and only one translation is in flight at a time.

Top module: `pgx_xlate`

## Requirements
- R1: The physical address equals the entry's frame number multiplied by 2^OFF_W, plus the offset from the low OFF_W bits of the logical address. A good translation reports fault code 00.
- R2: When the page number is in the cache, the response appears in the second cycle after acceptance and no memory read is issued.
- R3: A miss issues exactly one memory read at address `pt_base + page number`. In the entry read back, bit PTE_W-1 is the present flag, bit PTE_W-2 is the read-only flag, and the low FRAME_W bits are the frame. The response follows the read, and a later access to the same page hits.
- R4: An entry whose present flag is 0 gives fault code 01 with physical address 0. Such an entry is never cached, so every access to that page reads memory again.
- R5: A write to a page marked read-only gives fault code 10 with physical address 0, whether the entry came from the cache or from memory. A read of that page translates normally.
- R6: A flush pulse invalidates every cache entry, so the next access to any page reads memory. A lookup in the same cycle as a flush is treated as a miss.
- R7: A flush during a table read lets that read finish and answer correctly, but the entry is not cached, so the next access to that page reads memory.
- R8: Each cache fill writes the slot that a pointer selects, and the pointer then advances by one, wrapping after TLB_ENTRIES fills. Flushes leave the pointer unchanged. The fill after a full round therefore replaces the oldest fill and keeps the others.
- R9: `req_ready` is high only while no translation is in flight. A pending response holds its value until `rsp_ready`. A memory request holds its address until `mem_ack`.
- R10: During reset, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | VA_W | Logical address |
| req_write | input | 1 | Access is a write |
| pt_base | input | MA_W | Base address of the page table |
| flush | input | 1 | Invalidate all cached translations |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address (0 on fault) |
| rsp_fault | output | 2 | 00 ok, 01 page not present, 10 write to read-only |
| mem_req | output | 1 | Page-table read request |
| mem_addr | output | MA_W | Page-table entry address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | FRAME_W+2 | Page-table entry |

## Verification
The bench uses the default parameters: 12-bit logical addresses, 16-byte pages, 6-bit frames, a 10-bit table address and 8 cache slots. With these values the page-table memory is small enough to fill completely in the bench. Random traffic picks pages from a pool of twelve, which is larger than the cache, so round-robin eviction happens regularly alongside repeated hits. The table base rotates among three regions, and each change is paired with a flush, so the same page number maps to different entries over time and a stale cached mapping would show up in the results.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WALK = 2'd2,
    ST_RESP = 2'd3
  } pgx_state_e;

  localparam logic [1:0] FLT_NONE    = 2'b00;
  localparam logic [1:0] FLT_INVALID = 2'b01;
  localparam logic [1:0] FLT_PROT    = 2'b10;
endpackage

// File: rtl/pgx_tlb.sv
module pgx_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 8,
  parameter int FRAME_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  output logic               lk_ro,
  input  logic               inv_all,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_ro
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_vld;
  logic [ENTRIES-1:0] ent_hit;
  logic [ENTRIES-1:0] ent_we;
  logic [ENTRIES-1:0] ent_ro;
  logic [VPN_W-1:0]   ent_tag [ENTRIES];
  logic [FRAME_W-1:0] ent_frm [ENTRIES];
  logic [PTR_W-1:0]   vic_ptr_q, vic_ptr_d;
  logic               do_fill;

  // flush wins over a fill in the same cycle
  assign do_fill = fill_en & ~inv_all;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      assign ent_we[g]  = do_fill && (vic_ptr_q == PTR_W'(g));
      assign ent_hit[g] = ent_vld[g] && (ent_tag[g] == lk_vpn);
    end
  endgenerate

  always_comb begin
    vic_ptr_d = vic_ptr_q;
    if (do_fill) begin
      vic_ptr_d = (vic_ptr_q == PTR_W'(ENTRIES-1)) ? '0 : vic_ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld   <= '0;
      vic_ptr_q <= '0;
    end else begin
      if (do_fill) vic_ptr_q <= vic_ptr_d;
      if (inv_all) begin
        ent_vld <= '0;
      end else begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (ent_we[i]) ent_vld[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (ent_we[i]) begin
        ent_tag[i] <= fill_vpn;
        ent_frm[i] <= fill_frame;
        ent_ro[i]  <= fill_ro;
      end
    end
  end

  always_comb begin
    lk_frame = '0;
    lk_ro    = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ent_hit[i]) begin
        lk_frame = lk_frame | ent_frm[i];
        lk_ro    = lk_ro | ent_ro[i];
      end
    end
  end

  assign lk_hit = |ent_hit;
endmodule

// File: rtl/pgx_ctrl.sv
module pgx_ctrl
  import pgx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  input  logic flush,
  input  logic lk_hit,
  input  logic mem_ack,
  input  logic rsp_ready,
  output logic accept,
  output logic hit_done,
  output logic walk_start,
  output logic walk_done,
  output logic walk_commit,
  output logic mem_req,
  output logic rsp_valid
);
  pgx_state_e state_q, state_d;
  logic       drop_q, drop_d;
  logic       use_hit;

  assign use_hit     = lk_hit & ~flush;
  assign accept      = (state_q == ST_IDLE) & req_valid;
  assign hit_done    = (state_q == ST_LOOK) & use_hit;
  assign walk_start  = (state_q == ST_LOOK) & ~use_hit;
  assign walk_done   = (state_q == ST_WALK) & mem_ack;
  assign walk_commit = walk_done & ~drop_q & ~flush;
  assign mem_req     = (state_q == ST_WALK);
  assign rsp_valid   = (state_q == ST_RESP);
  assign req_ready   = (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_LOOK;
      ST_LOOK: state_d = use_hit ? ST_RESP : ST_WALK;
      ST_WALK: if (mem_ack) state_d = ST_RESP;
      ST_RESP: if (rsp_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    drop_d = drop_q;
    if (walk_start) begin
      drop_d = 1'b0;
    end else if ((state_q == ST_WALK) && flush) begin
      drop_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      drop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      drop_q  <= drop_d;
    end
  end
endmodule

// File: rtl/pgx_pte_check.sv
module pgx_pte_check
  import pgx_pkg::*;
#(
  parameter int FRAME_W = 6,
  parameter int OFF_W   = 4
) (
  input  logic                     pg_present,
  input  logic                     pg_ro,
  input  logic                     is_write,
  input  logic [FRAME_W-1:0]       frame,
  input  logic [OFF_W-1:0]         offset,
  output logic [1:0]               fault,
  output logic [FRAME_W+OFF_W-1:0] paddr
);
  always_comb begin
    if (!pg_present) begin
      fault = FLT_INVALID;
      paddr = '0;
    end else if (pg_ro && is_write) begin
      fault = FLT_PROT;
      paddr = '0;
    end else begin
      fault = FLT_NONE;
      paddr = {frame, offset};
    end
  end
endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate #(
  parameter int VA_W        = 12,
  parameter int OFF_W       = 4,
  parameter int FRAME_W     = 6,
  parameter int MA_W        = 10,
  parameter int TLB_ENTRIES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VA_W-1:0]          req_addr,
  input  logic                     req_write,
  input  logic [MA_W-1:0]          pt_base,
  input  logic                     flush,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
  output logic [1:0]               rsp_fault,
  output logic                     mem_req,
  output logic [MA_W-1:0]          mem_addr,
  input  logic                     mem_ack,
  input  logic [FRAME_W+1:0]       mem_rdata
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = FRAME_W + OFF_W;
  localparam int PTE_W = FRAME_W + 2;

  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic [MA_W-1:0]    base_q;
  logic [PA_W-1:0]    paddr_q, paddr_d;
  logic [1:0]         fault_q, fault_d;

  logic               accept, hit_done, walk_start, walk_done, walk_commit;
  logic               lk_hit, lk_ro;
  logic [FRAME_W-1:0] lk_frame;
  logic [VPN_W-1:0]   cur_vpn;
  logic [OFF_W-1:0]   cur_off;

  logic               pte_present, pte_ro;
  logic [FRAME_W-1:0] pte_frame;
  logic               src_present, src_ro;
  logic [FRAME_W-1:0] src_frame;

  assign cur_vpn     = va_q[VA_W-1:OFF_W];
  assign cur_off     = va_q[OFF_W-1:0];
  assign pte_present = mem_rdata[PTE_W-1];
  assign pte_ro      = mem_rdata[PTE_W-2];
  assign pte_frame   = mem_rdata[FRAME_W-1:0];

  pgx_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .flush       (flush),
    .lk_hit      (lk_hit),
    .mem_ack     (mem_ack),
    .rsp_ready   (rsp_ready),
    .accept      (accept),
    .hit_done    (hit_done),
    .walk_start  (walk_start),
    .walk_done   (walk_done),
    .walk_commit (walk_commit),
    .mem_req     (mem_req),
    .rsp_valid   (rsp_valid)
  );

  pgx_tlb #(
    .ENTRIES (TLB_ENTRIES),
    .VPN_W   (VPN_W),
    .FRAME_W (FRAME_W)
  ) u_tlb (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_vpn     (cur_vpn),
    .lk_hit     (lk_hit),
    .lk_frame   (lk_frame),
    .lk_ro      (lk_ro),
    .inv_all    (flush),
    .fill_en    (walk_commit & pte_present),
    .fill_vpn   (cur_vpn),
    .fill_frame (pte_frame),
    .fill_ro    (pte_ro)
  );

  // pick the source of the mapping: cached slot or fetched entry
  always_comb begin
    if (hit_done) begin
      src_present = 1'b1;
      src_ro      = lk_ro;
      src_frame   = lk_frame;
    end else begin
      src_present = pte_present;
      src_ro      = pte_ro;
      src_frame   = pte_frame;
    end
  end

  pgx_pte_check #(
    .FRAME_W (FRAME_W),
    .OFF_W   (OFF_W)
  ) u_chk_pte (
    .pg_present (src_present),
    .pg_ro      (src_ro),
    .is_write   (wr_q),
    .frame      (src_frame),
    .offset     (cur_off),
    .fault      (fault_d),
    .paddr      (paddr_d)
  );

  assign mem_addr = base_q + MA_W'(cur_vpn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q    <= '0;
      wr_q    <= 1'b0;
      base_q  <= '0;
      paddr_q <= '0;
      fault_q <= '0;
    end else begin
      if (accept) begin
        va_q <= req_addr;
        wr_q <= req_write;
      end
      if (walk_start) base_q <= pt_base;
      if (hit_done || walk_done) begin
        paddr_q <= paddr_d;
        fault_q <= fault_d;
      end
    end
  end

  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;
endmodule

// File: rtl/pgx_xlate_chk.sv
module pgx_xlate_chk #(
  parameter int VA_W        = 12,
  parameter int OFF_W       = 4,
  parameter int FRAME_W     = 6,
  parameter int MA_W        = 10,
  parameter int TLB_ENTRIES = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [OFF_W-1:0]         req_off,
  input logic                     rsp_valid,
  input logic                     rsp_ready,
  input logic [FRAME_W+OFF_W-1:0] rsp_paddr,
  input logic [1:0]               rsp_fault,
  input logic                     mem_req,
  input logic                     mem_ack,
  input logic [MA_W-1:0]          mem_addr
);
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= '0;
    else if (req_valid && req_ready) off_q <= req_off;
  end

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'b00) |-> rsp_paddr[OFF_W-1:0] == off_q); // R1
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !rsp_valid); // R3
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> rsp_paddr == '0); // R4
  AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'b11); // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req) |-> !req_ready); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault))); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R9
endmodule

bind pgx_xlate pgx_xlate_chk #(
  .VA_W        (VA_W),
  .OFF_W       (OFF_W),
  .FRAME_W     (FRAME_W),
  .MA_W        (MA_W),
  .TLB_ENTRIES (TLB_ENTRIES)
) u_xlate_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_off   (req_addr[OFF_W-1:0]),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_paddr (rsp_paddr),
  .rsp_fault (rsp_fault),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr)
);

// File: tb/tb_pgx_xlate.sv
module tb_pgx_xlate;
  localparam int VA_W = 12, OFF_W = 4, FRAME_W = 6, MA_W = 10, NENT = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write, flush, rsp_valid, rsp_ready;
  logic mem_req, mem_ack;
  logic [VA_W-1:0] req_addr;
  logic [MA_W-1:0] pt_base, mem_addr;
  logic [9:0] rsp_paddr;
  logic [1:0] rsp_fault;
  logic [7:0] mem_rdata;

  always #4 clk = ~clk;

  pgx_xlate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .pt_base(pt_base), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  logic [7:0] pmem [1024];
  int  checks = 0, fails = 0, walk_cnt = 0, lat_cnt = 0, last_maddr = 0;
  bit  mem_hold = 1'b0;

  int  m_vpn [NENT];
  int  m_pte [NENT];
  bit  m_val [NENT];
  int  m_ptr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int model_find(input int vpn);
    for (int i = 0; i < NENT; i++) if (m_val[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic int exp_fault(input int pte, input bit wr);
    if (((pte >> 7) & 1) == 0) return 1;
    if ((((pte >> 6) & 1) == 1) && wr) return 2;
    return 0;
  endfunction

  function automatic int exp_paddr(input int pte, input bit wr, input int off);
    if (exp_fault(pte, wr) != 0) return 0;
    return ((pte & 63) << OFF_W) | off;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NENT; i++) m_val[i] = 1'b0;
  endtask

  // memory read port model: random latency, optional hold
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req && !mem_hold) begin
      if (lat_cnt == 0) begin
        mem_ack    = 1'b1;
        mem_rdata  = pmem[mem_addr];
        walk_cnt++;
        last_maddr = int'(mem_addr);
        lat_cnt    = int'($urandom % 3);
      end else begin
        lat_cnt--;
      end
    end
  end

  task automatic do_flush(input int new_base);
    @(negedge clk);
    flush = 1'b1;
    pt_base = MA_W'(new_base);
    @(negedge clk);
    flush = 1'b0;
    model_clear();
  endtask

  // mode 0: normal, 1: flush during the table read, 2: response held back
  task automatic xlate(input int va, input bit wr, input string req, input int mode);
    int vpn, off, idx, pte, addr, w0, n, hold_pa, hold_ft;
    bit hit;
    vpn  = va >> OFF_W;
    off  = va & ((1 << OFF_W) - 1);
    idx  = model_find(vpn);
    hit  = (idx >= 0);
    addr = (int'(pt_base) + vpn) & 1023;
    pte  = hit ? m_pte[idx] : int'(pmem[addr]);
    w0   = walk_cnt;
    if (mode == 1) mem_hold = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready when idle", int'(req_ready), 1);
    req_addr  = VA_W'(va);
    req_write = wr;
    req_valid = 1'b1;
    if (mode == 2) rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    chk(req_ready == 1'b0, "R9", "ready while busy", int'(req_ready), 0);
    if (mode == 1) begin
      while (!mem_req && n < 100) begin @(negedge clk); n++; end
      flush = 1'b1;
      model_clear();
      @(negedge clk);
      flush = 1'b0;
      mem_hold = 1'b0;
      n++;
    end
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    chk(rsp_valid == 1'b1, req, "response arrives", int'(rsp_valid), 1);
    chk(int'(rsp_fault) == exp_fault(pte, wr), req, "fault code", int'(rsp_fault), exp_fault(pte, wr));
    chk(int'(rsp_paddr) == exp_paddr(pte, wr, off), req, "physical address",
        int'(rsp_paddr), exp_paddr(pte, wr, off));
    if (hit) begin
      chk(walk_cnt == w0, "R2", "no table read on hit", walk_cnt - w0, 0);
      chk(n == 2, "R2", "hit latency", n, 2);
    end else begin
      chk(walk_cnt == w0 + 1, "R3", "one table read on miss", walk_cnt - w0, 1);
      chk(last_maddr == addr, "R3", "entry address", last_maddr, addr);
    end
    if (mode == 2) begin
      hold_pa = int'(rsp_paddr);
      hold_ft = int'(rsp_fault);
      repeat (3) begin
        @(negedge clk);
        chk(rsp_valid == 1'b1 && int'(rsp_paddr) == hold_pa && int'(rsp_fault) == hold_ft,
            "R9", "response held", int'(rsp_paddr), hold_pa);
      end
      rsp_ready = 1'b1;
    end
    if (!hit && ((pte >> 7) & 1) == 1 && mode != 1) begin
      m_vpn[m_ptr] = vpn;
      m_pte[m_ptr] = pte;
      m_val[m_ptr] = 1'b1;
      m_ptr = (m_ptr + 1) % NENT;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int w0;
    void'($urandom(32'd7310));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    pt_base = '0; flush = 1'b0; rsp_ready = 1'b1; mem_ack = 1'b0; mem_rdata = '0;
    model_clear();
    for (int i = 0; i < 1024; i++) begin
      int r;
      r = int'($urandom % 100);
      pmem[i] = {(r < 80) ? 1'b1 : 1'b0, (r % 4 == 0) ? 1'b1 : 1'b0, 6'($urandom)};
    end
    pmem[3] = 8'h82; pmem[5] = 8'h00; pmem[6] = 8'hC7; pmem[9] = 8'h89;
    for (int i = 16; i < 25; i++) pmem[i] = 8'h80 | 8'(i);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready in reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R10", "no response in reset", int'(rsp_valid), 0);
    chk(mem_req == 1'b0, "R10", "no table read in reset", int'(mem_req), 0);
    rst_n = 1'b1;

    // R1 R3: page 3 in frame 2, then R2 hit
    xlate(32'h031, 1'b0, "R1", 0);
    chk(int'(rsp_paddr) == 32'h021, "R1", "page3 frame2 offset1", int'(rsp_paddr), 32'h021);
    xlate(32'h03A, 1'b1, "R2", 0);
    // R4: absent page never cached
    xlate(32'h052, 1'b0, "R4", 0);
    xlate(32'h057, 1'b0, "R4", 0);
    // R5: read-only page, write faults on miss and on hit, read succeeds
    xlate(32'h064, 1'b1, "R5", 0);
    xlate(32'h065, 1'b0, "R5", 0);
    xlate(32'h066, 1'b1, "R5", 0);
    // R6: flush forces a table read
    do_flush(0);
    w0 = walk_cnt;
    xlate(32'h031, 1'b0, "R6", 0);
    chk(walk_cnt == w0 + 1, "R6", "read after flush", walk_cnt - w0, 1);
    // R7: flush during table read completes but does not cache
    xlate(32'h093, 1'b0, "R7", 1);
    w0 = walk_cnt;
    xlate(32'h094, 1'b0, "R7", 0);
    chk(walk_cnt == w0 + 1, "R7", "not cached after mid-read flush", walk_cnt - w0, 1);
    // R8: round-robin replacement
    do_flush(0);
    for (int p = 16; p < 24; p++) xlate(p << OFF_W, 1'b0, "R8", 0);
    w0 = walk_cnt;
    for (int p = 16; p < 24; p++) xlate((p << OFF_W) | 5, 1'b0, "R8", 0);
    chk(walk_cnt == w0, "R8", "full cache all hit", walk_cnt - w0, 0);
    xlate(24 << OFF_W, 1'b0, "R8", 0);
    w0 = walk_cnt;
    for (int p = 17; p < 24; p++) xlate(p << OFF_W, 1'b0, "R8", 0);
    chk(walk_cnt == w0, "R8", "survivors still hit", walk_cnt - w0, 0);
    xlate(16 << OFF_W, 1'b0, "R8", 0);
    chk(walk_cnt == w0 + 1, "R8", "oldest evicted", walk_cnt - w0, 1);
    // R9: response held while consumer stalls
    xlate(32'h033, 1'b0, "R9", 2);

    // random traffic over twelve pages and three table bases
    for (int k = 0; k < 400; k++) begin
      int va;
      if ($urandom % 100 < 4) do_flush(int'($urandom % 3) * 256);
      va = (int'($urandom % 12) << OFF_W) | int'($urandom % 16);
      xlate(va, 1'($urandom % 2), "R1", 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule